// File: doc/BRIEF.md
# Completion Interrupt Coalescing Unit

This unit sits beside a memory-copy engine and turns its stream of per-descriptor completion pulses into a single, rate-limited interrupt request. In coalescing mode it keeps a running count of completions not yet reported. It raises its done status when that count goes past a programmable count limit. It also raises the status when the oldest unreported completion has waited longer than a programmable age limit. The age is measured in units of a fixed number of microsecond ticks, 20 by default. When coalescing is turned off, every completion sets the done status on the next clock.

Software sees three word registers. The first is a configuration word holding the coalescing enable, the count limit and the age limit. The second is a status word whose done bit is cleared by writing one to it. The third is a mask word that gates the done bit onto the interrupt line. A service routine masks the line while it works, writes the status it read back to acknowledge it, and then unmasks the line.

Top module: `coal_irq_unit`

## Requirements
- R1: After reset the configuration word reads 0x8014_0014: coalescing enabled in bit 31, count limit 20 in bits 22:16, age limit 20 in bits 6:0. The status and mask words read 0 and `irq` is low.
- R2: With coalescing off (bit 31 clear), each `done_pulse` sets the status done bit (bit 0 of the word at offset 0x4) one clock later.
- R3: With coalescing on, the done bit sets one clock after the number of pending completions becomes greater than the count limit.
- R4: With coalescing on and at least one completion pending, the done bit sets one clock after the elapsed age becomes greater than the age limit. One age unit is 20 `us_tick` cycles.
- R5: `us_tick` pulses while nothing is pending leave the age at zero, so no interrupt comes from the age path.
- R6: Setting the done bit restarts both the pending count and the age at zero, so the next report again needs the full count or age.
- R7: Writing a 1 to bit 0 of the status word clears the done bit, and writing 0 leaves it unchanged.
- R8: When a done-setting event and a clearing write to the status word fall in the same clock, the done bit stays set. A completion pulse in that clock still counts as pending.
- R9: `irq` equals the done bit ANDed with mask bit 0 (offset 0x8).
- R10: The configuration word at offset 0x0 and the mask word read back what was written, restricted to their defined bits. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_pulse | input | 1 | One completed receive descriptor in this clock |
| us_tick | input | 1 | Microsecond time-base strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pending count or age value inside the unit shows up only as a done bit that sets too early or too late. The status read and `irq` therefore shift by one or more clocks against the model, and the per-clock comparison catches that at the first cycle of disagreement. A mishandled same-clock clear or a lost restart shows up within a single threshold period, when the next report arrives at a different clock. Register corruption appears at once on the readback of the word being addressed.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic [1:0] {
      SEL_CFG  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int DONE_BIT = 0;
endpackage

// File: rtl/coal_pend_ctr.sv
module coal_pend_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = '1;

   logic [W-1:0] base;

   assign base = clr ? '0 : cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc && base != MAXV)
         cnt <= base + W'(1);
      else
         cnt <= base;
   end
endmodule

// File: rtl/coal_age_timer.sv
module coal_age_timer #(
   parameter int TPU = 20,
   parameter int UW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [UW-1:0] units
);
   localparam logic [UW-1:0] UMAX = '1;

   logic step;

   generate
      if (TPU == 1) begin : g_direct
         assign step = tick;
      end else begin : g_prescale
         localparam int PW = $clog2(TPU);
         localparam logic [PW-1:0] LAST = PW'(TPU - 1);
         logic [PW-1:0] pre_q;

         assign step = tick && (pre_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               pre_q <= '0;
            else if (tick)
               pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         units <= '0;
      else if (step && units != UMAX)
         units <= units + UW'(1);
   end
endmodule

// File: rtl/coal_irq_unit.sv
module coal_irq_unit
   import coal_pkg::*;
#(
   parameter int AW             = 4,
   parameter int CNT_W          = 7,
   parameter int TIME_W         = 7,
   parameter int TICKS_PER_UNIT = 20,
   parameter int EN_BIT         = 31,
   parameter int CNT_LSB        = 16,
   parameter int TIME_LSB       = 0,
   parameter int DEF_CNT        = 20,
   parameter int DEF_TIME       = 20,
   parameter bit DEF_EN         = 1'b1,
   parameter int CFG_OFS        = 0,
   parameter int STAT_OFS       = 4,
   parameter int MASK_OFS       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          done_pulse,
   input  logic          us_tick,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq
);
   localparam int PEND_W = CNT_W + 1;
   localparam int UNIT_W = TIME_W + 1;

   generate
      if (CNT_LSB + CNT_W > 32 || TIME_LSB + TIME_W > 32 || EN_BIT > 31)
         $error("coal_irq_unit: configuration field outside 32-bit word");
      if (TICKS_PER_UNIT < 1)
         $error("coal_irq_unit: TICKS_PER_UNIT must be at least 1");
      if (DEF_CNT >= (1 << CNT_W) || DEF_TIME >= (1 << TIME_W))
         $error("coal_irq_unit: default limit does not fit its field");
   endgenerate

   reg_sel_e              sel;
   logic                  dly_en_q;
   logic [CNT_W-1:0]      cnt_lim_q;
   logic [TIME_W-1:0]     time_lim_q;
   logic                  stat_q;
   logic                  mask_q;
   logic [PEND_W-1:0]     pend_q;
   logic [UNIT_W-1:0]     units_q;
   logic                  fire;
   logic                  set_done;
   logic                  ack;
   logic [31:0]           cfg_word;

   always_comb begin
      if (reg_addr == AW'(CFG_OFS))       sel = SEL_CFG;
      else if (reg_addr == AW'(STAT_OFS)) sel = SEL_STAT;
      else if (reg_addr == AW'(MASK_OFS)) sel = SEL_MASK;
      else                                sel = SEL_NONE;
   end

   assign fire     = dly_en_q && ((pend_q > PEND_W'(cnt_lim_q)) ||
                                  (units_q > UNIT_W'(time_lim_q)));
   assign set_done = fire || (!dly_en_q && done_pulse);
   assign ack      = reg_wr && (sel == SEL_STAT) && reg_wdata[DONE_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dly_en_q   <= DEF_EN;
         cnt_lim_q  <= CNT_W'(DEF_CNT);
         time_lim_q <= TIME_W'(DEF_TIME);
         mask_q     <= 1'b0;
      end else if (reg_wr) begin
         if (sel == SEL_CFG) begin
            dly_en_q   <= reg_wdata[EN_BIT];
            cnt_lim_q  <= reg_wdata[CNT_LSB +: CNT_W];
            time_lim_q <= reg_wdata[TIME_LSB +: TIME_W];
         end
         if (sel == SEL_MASK)
            mask_q <= reg_wdata[DONE_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         stat_q <= 1'b0;
      else if (set_done)
         stat_q <= 1'b1;
      else if (ack)
         stat_q <= 1'b0;
   end

   coal_pend_ctr #(.W(PEND_W)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!dly_en_q || fire),
      .inc   (dly_en_q && done_pulse),
      .cnt   (pend_q)
   );

   coal_age_timer #(.TPU(TICKS_PER_UNIT), .UW(UNIT_W)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!dly_en_q || fire || (pend_q == '0)),
      .tick  (us_tick),
      .units (units_q)
   );

   always_comb begin
      cfg_word                        = '0;
      cfg_word[EN_BIT]                = dly_en_q;
      cfg_word[CNT_LSB +: CNT_W]      = cnt_lim_q;
      cfg_word[TIME_LSB +: TIME_W]    = time_lim_q;
      case (sel)
         SEL_CFG:  reg_rdata = cfg_word;
         SEL_STAT: reg_rdata = 32'(stat_q) << DONE_BIT;
         SEL_MASK: reg_rdata = 32'(mask_q) << DONE_BIT;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = stat_q && mask_q;

   // R3 R4
   fire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> stat_q);

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dly_en_q && done_pulse) |=> stat_q);

   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !dly_en_q && !done_pulse) |=> !irq);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q <= PEND_W'(1 << CNT_W));

   // R5
   idle_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q == '0) |-> (units_q == '0));
endmodule

// File: tb/sim_coal_irq_unit.sv
module sim_coal_irq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done_pulse = 1'b0;
   logic        us_tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   string phase = "R1";

   // reference model state
   int       m_pend, m_ticks, m_units;
   bit       m_stat, m_mask;
   bit [31:0] m_cfg;

   always #10 clk = ~clk;

   coal_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .us_tick(us_tick),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   always @(posedge clk) begin
      int  en, cl, tl;
      bit  fire, ack;
      if (!rst_n) begin
         m_pend = 0; m_ticks = 0; m_units = 0;
         m_stat = 0; m_mask = 0; m_cfg = 32'h8014_0014;
      end else begin
         en   = int'(m_cfg[31]);
         cl   = int'(m_cfg[22:16]);
         tl   = int'(m_cfg[6:0]);
         fire = (en != 0) && (m_pend > cl || m_units > tl);
         ack  = reg_wr && reg_addr == 4'h4 && reg_wdata[0];
         if (fire || (en == 0 && done_pulse)) m_stat = 1;
         else if (ack) m_stat = 0;
         if (en == 0 || fire || m_pend == 0) begin
            m_ticks = 0; m_units = 0;
         end else if (us_tick) begin
            if (m_ticks == 19) begin m_ticks = 0; m_units++; end
            else m_ticks++;
         end
         if (en == 0) m_pend = 0;
         else m_pend = (fire ? 0 : m_pend) + int'(done_pulse);
         if (reg_wr && reg_addr == 4'h0) m_cfg = reg_wdata & 32'h807F_007F;
         if (reg_wr && reg_addr == 4'h8) m_mask = reg_wdata[0];
      end
   end

   function automatic logic [31:0] exp_rd(logic [3:0] a);
      case (a)
         4'h0:    return m_cfg;
         4'h4:    return {31'h0, m_stat};
         4'h8:    return {31'h0, m_mask};
         default: return 32'h0;
      endcase
   endfunction

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq !== (m_stat & m_mask) || reg_rdata !== exp_rd(reg_addr)) begin
            fails++;
            $display("FAIL %s model: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                     phase, irq, reg_rdata, m_stat & m_mask, exp_rd(reg_addr));
         end
      end
   end

   task automatic cyc(bit p, bit t, bit w, logic [3:0] a, logic [31:0] d);
      @(posedge clk); #5;
      done_pulse = p; us_tick = t; reg_wr = w; reg_addr = a; reg_wdata = d;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(int n, logic [3:0] a);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, a, 0);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      bit [15:0] lfsr;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      // R1 reset values
      phase = "R1";
      cyc(0, 0, 0, 4'h0, 0); #1 chk("R1 cfg", reg_rdata, 32'h8014_0014);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R1 stat", reg_rdata, 32'h0);
      cyc(0, 0, 0, 4'h8, 0); #1 chk("R1 mask", reg_rdata, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      // R10 readback
      phase = "R10";
      cyc(0, 0, 1, 4'h8, 32'hFFFF_FFFF);
      cyc(0, 0, 0, 4'h8, 0); #1 chk("R10 mask", reg_rdata, 32'h1);
      cyc(0, 0, 1, 4'h0, 32'h7FFF_FF00);
      cyc(0, 0, 0, 4'h0, 0); #1 chk("R10 cfg", reg_rdata, 32'h007F_0000);
      cyc(0, 0, 0, 4'hC, 0); #1 chk("R10 other", reg_rdata, 32'h0);
      // R2 bypass mode
      phase = "R2";
      cyc(1, 0, 0, 4'h4, 0);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R2 stat", reg_rdata, 32'h1);
      chk("R9 irq", {31'h0, irq}, 32'h1);
      // R7 write-one-to-clear
      phase = "R7";
      cyc(0, 0, 1, 4'h4, 32'h0);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R7 write0", reg_rdata, 32'h1);
      cyc(0, 0, 1, 4'h4, 32'h1);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R7 write1", reg_rdata, 32'h0);
      // R8 same-clock pulse and clear
      phase = "R8";
      cyc(1, 0, 0, 4'h4, 0);
      cyc(1, 0, 1, 4'h4, 32'h1);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R8 stat", reg_rdata, 32'h1);
      // R9 masking
      phase = "R9";
      cyc(0, 0, 1, 4'h8, 32'h0);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R9 masked", {31'h0, irq}, 32'h0);
      cyc(0, 0, 1, 4'h8, 32'h1);
      cyc(0, 0, 1, 4'h4, 32'h1);
      // R3 count threshold: limit 3, age limit max
      phase = "R3";
      cyc(0, 0, 1, 4'h0, 32'h8003_007F);
      for (int i = 0; i < 4; i++) cyc(1, 0, 0, 4'h4, 0);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R3 early", reg_rdata, 32'h0);
      cyc(0, 0, 0, 4'h4, 0); #1 chk("R3 fired", reg_rdata, 32'h1);
      // R6 restart after report; R8 pulse during fire counted
      phase = "R6";
      cyc(0, 0, 1, 4'h4, 32'h1);
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 4'h4, 0);
      idle(3, 4'h4); #1 chk("R6 no refire", reg_rdata, 32'h0);
      cyc(1, 0, 0, 4'h4, 0);
      idle(2, 4'h4); #1 chk("R6 refire", reg_rdata, 32'h1);
      for (int i = 0; i < 6; i++) cyc(1, 0, (i == 2), 4'h4, 32'h1);
      // R4 age threshold: age limit 2
      phase = "R4";
      cyc(0, 0, 1, 4'h0, 32'h807F_0002);
      cyc(0, 0, 1, 4'h4, 32'h1);
      idle(2, 4'h4);
      cyc(1, 0, 0, 4'h4, 0);
      for (int i = 0; i < 59; i++) cyc(0, 1, 0, 4'h4, 0);
      cyc(0, 1, 0, 4'h4, 0); #1 chk("R4 early", reg_rdata, 32'h0);
      idle(2, 4'h4); #1 chk("R4 fired", reg_rdata, 32'h1);
      // R5 ticks with nothing pending
      phase = "R5";
      cyc(0, 0, 1, 4'h4, 32'h1);
      for (int i = 0; i < 300; i++) cyc(0, 1, 0, 4'h4, 0);
      #1 chk("R5 idle", reg_rdata, 32'h0);
      // mixed traffic at default limits, compared every clock
      phase = "R3 R4 R7 mixed";
      cyc(0, 0, 1, 4'h0, 32'h8014_0014);
      lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0] & lfsr[3] & lfsr[7], lfsr[1] | lfsr[5],
             lfsr[2] & lfsr[4] & lfsr[6] & lfsr[9],
             lfsr[8] ? 4'h4 : {lfsr[11:10], 2'b00}, {31'h0, lfsr[12]});
      end
      idle(2, 4'h4);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule